// File: doc/BRIEF.md
# Line-Synchronized Display Register Latch

This block holds the display controls that a CPU writes for a raster display. The controls are two mode registers and a pattern-name base register. A write that changes the screen mode or the display-enable bit must not take effect mid-line. Such a write is kept in a shadow copy and moved into the active copy when the raster timing pulses its line-end strobe. The pattern-name base has no shadow copy. It reaches its output on the cycle after the write, so a base-address split can land part way along a line. A write made while horizontal blanking is in progress waits one extra line boundary before it takes effect.

The CPU writes through a one-byte port. Each register write is two bytes: first the data byte, then a byte that carries the register number in bits 6:0 and has bit 7 set. The port decoder is a two-state machine:
- `PORT_WAIT_DATA`: any byte is stored as data, and the transition *take data* moves to `PORT_WAIT_NUM`.
- `PORT_WAIT_NUM`: a byte with bit 7 set commits the write (transition *commit*). A byte with bit 7 clear drops the sequence (transition *abandon*). Both return to `PORT_WAIT_DATA`.

Each of the two deferred registers has a slot machine:
- `SLOT_ON_TIME`: the shadow value is applied at the next strobe.
- `SLOT_LATE`: a value written during blanking is parked. The transition *park* enters this state. The transition *promote* happens at the next strobe: it moves the parked value into the shadow and returns to `SLOT_ON_TIME`. The transition *supersede* is a newer write made outside blanking; it also returns to `SLOT_ON_TIME`.

Top module: `disp_reg_latch`

## Requirements
- R1: After reset, `mode_act`, `disp_en` and `name_base` are all zero.
- R2: A data byte alone changes no output. A register write commits only when the second byte, with bit 7 set, arrives.
- R3: A second byte with bit 7 clear abandons the sequence and changes no output. The byte after it is taken as a new data byte.
- R4: A write to register 2 appears on `name_base` one cycle after the committing byte, with no strobe needed.
- R5: `disp_en` shows bit 6 of register 1. A change to it appears only on the cycle after a `line_end` strobe.
- R6: `mode_act[4:2]` shows register 0 bits 3:1, and `mode_act[1:0]` shows register 1 bits 4:3. A change to either appears only on the cycle after a `line_end` strobe.
- R7: When a deferred register is written several times within one line, only the last value is applied at the strobe.
- R8: A deferred write committed while `hblank` is high and `line_end` is low is not applied at the next strobe. It is applied at the strobe after that.
- R9: A deferred write committed in the same cycle as a `line_end` strobe is not applied at that strobe. It is applied at the next one.
- R10: Writes to register numbers 3 to 127 change no output, even after a strobe.
- R11: A deferred write made outside blanking replaces a parked blanking-time value that has not yet been promoted. The newer value is applied at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Port byte valid this cycle |
| wr_data | input | 8 | Port byte |
| hblank | input | 1 | High during horizontal blanking |
| line_end | input | 1 | One-cycle strobe at the line boundary (last cycle of blanking) |
| mode_act | output | 5 | Active screen-mode bits |
| disp_en | output | 1 | Active display enable; 0 blanks the picture |
| name_base | output | 8 | Pattern-name table base, immediate |

## Verification
The bench sweeps every byte value through registers 0, 1 and 2. Before each strobe it checks that the deferred outputs still hold the old value, and after the strobe that they hold the new one. A design that applies mode or blank writes at once would fail the check before the strobe. A design that deferred the base register would leave `name_base` stale.

Directed cases cover the timing corners:
- A write during blanking. A design that ignores `hblank` would apply it one line early.
- A write that lands exactly on the strobe. A design that forwards it into the active copy would act a line too soon.
- A parked value that a later write replaces. A design with a single pending slot would apply the stale value.
- The port sequencing. A design that commits on the data byte, or does not resynchronise after an abandoned sequence, would write the wrong register or the wrong value.

// File: rtl/disp_reg_pkg.sv
package disp_reg_pkg;

    parameter int BYTE_W = 8;
    parameter int NUM_W  = BYTE_W - 1;
    parameter int DEFER_CNT = 2;

    localparam int REG_NAME = 2;

    localparam int BLANK_BIT = 6;
    localparam int M0_LO = 1;
    localparam int M0_HI = 3;
    localparam int M1_LO = 3;
    localparam int M1_HI = 4;
    localparam int M0_W = M0_HI - M0_LO + 1;
    localparam int M1_W = M1_HI - M1_LO + 1;
    localparam int MODE_W = M0_W + M1_W;

    typedef enum logic [0:0] {
        PORT_WAIT_DATA = 1'b0,
        PORT_WAIT_NUM  = 1'b1
    } port_state_t;

    typedef enum logic [0:0] {
        SLOT_ON_TIME = 1'b0,
        SLOT_LATE    = 1'b1
    } slot_state_t;

    typedef struct packed {
        logic              vld;
        logic [NUM_W-1:0]  num;
        logic [BYTE_W-1:0] data;
    } commit_t;

endpackage

// File: rtl/disp_port_decoder.sv
module disp_port_decoder
    import disp_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output commit_t           commit,
    output port_state_t       state_o
);

    port_state_t       state_q, state_d;
    logic [BYTE_W-1:0] held_q, held_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PORT_WAIT_DATA;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        held_d      = held_q;
        commit.vld  = 1'b0;
        commit.num  = wr_data[NUM_W-1:0];
        commit.data = held_q;
        if (wr_en) begin
            unique case (state_q)
                PORT_WAIT_DATA: begin
                    held_d  = wr_data;          // take data
                    state_d = PORT_WAIT_NUM;
                end
                PORT_WAIT_NUM: begin
                    state_d = PORT_WAIT_DATA;
                    if (wr_data[BYTE_W-1]) begin
                        commit.vld = 1'b1;      // commit
                    end                         // else abandon
                end
                default: state_d = PORT_WAIT_DATA;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/disp_defer_slot.sv
module disp_defer_slot
    import disp_reg_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    input  logic         hblank,
    input  logic         line_end,
    output logic [W-1:0] active,
    output logic         late_o
);

    slot_state_t  st_q, st_d;
    logic [W-1:0] near_q, near_d;
    logic [W-1:0] park_q, park_d;
    logic [W-1:0] act_q, act_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SLOT_ON_TIME;
            near_q <= '0;
            park_q <= '0;
            act_q  <= '0;
        end else begin
            st_q   <= st_d;
            near_q <= near_d;
            park_q <= park_d;
            act_q  <= act_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        near_d = near_q;
        park_d = park_q;
        act_d  = act_q;
        if (line_end) begin
            act_d = near_q;
            unique case (st_q)
                SLOT_LATE: begin
                    near_d = park_q;            // promote
                    st_d   = SLOT_ON_TIME;
                end
                SLOT_ON_TIME: ;
                default: st_d = SLOT_ON_TIME;
            endcase
        end
        if (wr_hit) begin
            if (hblank && !line_end) begin
                park_d = wr_data;               // park
                st_d   = SLOT_LATE;
            end else begin
                near_d = wr_data;               // supersede / on time
                st_d   = SLOT_ON_TIME;
            end
        end
    end

    assign active = act_q;
    assign late_o = (st_q == SLOT_LATE);

endmodule

// File: rtl/disp_reg_latch.sv
module disp_reg_latch
    import disp_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              hblank,
    input  logic              line_end,
    output logic [MODE_W-1:0] mode_act,
    output logic              disp_en,
    output logic [BYTE_W-1:0] name_base
);

    commit_t           commit;
    port_state_t       port_state;
    logic [DEFER_CNT-1:0] slot_late;
    logic [BYTE_W-1:0] act_reg [DEFER_CNT];
    logic [BYTE_W-1:0] base_q;

    disp_port_decoder u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .commit  (commit),
        .state_o (port_state)
    );

    for (genvar g = 0; g < DEFER_CNT; g++) begin : gen_slot
        logic hit;
        assign hit = commit.vld && (commit.num == NUM_W'(g));
        disp_defer_slot #(.W(BYTE_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (hit),
            .wr_data  (commit.data),
            .hblank   (hblank),
            .line_end (line_end),
            .active   (act_reg[g]),
            .late_o   (slot_late[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (commit.vld && commit.num == NUM_W'(REG_NAME)) begin
            base_q <= commit.data;
        end
    end

    always_comb begin
        mode_act  = {act_reg[0][M0_HI:M0_LO], act_reg[1][M1_HI:M1_LO]};
        disp_en   = act_reg[1][BLANK_BIT];
        name_base = base_q;
    end

endmodule

// File: rtl/disp_reg_latch_checker.sv
module disp_reg_latch_checker
    import disp_reg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [BYTE_W-1:0] wr_data,
    input logic              hblank,
    input logic              line_end,
    input logic [MODE_W-1:0] mode_act,
    input logic              disp_en,
    input logic [BYTE_W-1:0] name_base,
    input port_state_t       port_state,
    input logic [DEFER_CNT-1:0] slot_late
);

    p_defer_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en != $past(disp_en)) |-> $past(line_end));

    p_defer_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act != $past(mode_act)) |-> $past(line_end));

    p_base_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (name_base != $past(name_base)) |->
            ($past(wr_en) && $past(wr_data[BYTE_W-1]) && $past(port_state) == PORT_WAIT_NUM));

    p_port_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (port_state == $past(port_state)));

    p_park_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_late[0]) |-> $past(hblank && !line_end));

    p_park_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_late[1]) |-> $past(hblank && !line_end));

endmodule

bind disp_reg_latch disp_reg_latch_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .hblank     (hblank),
    .line_end   (line_end),
    .mode_act   (mode_act),
    .disp_en    (disp_en),
    .name_base  (name_base),
    .port_state (port_state),
    .slot_late  (slot_late)
);

// File: tb/disp_reg_latch_test.sv
module disp_reg_latch_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       hblank = 1'b0;
    logic       line_end = 1'b0;
    logic [4:0] mode_act;
    logic       disp_en;
    logic [7:0] name_base;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    disp_reg_latch uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .hblank(hblank), .line_end(line_end),
        .mode_act(mode_act), .disp_en(disp_en), .name_base(name_base)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input logic strobe);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b; line_end = strobe;
        @(negedge clk);
        wr_en = 1'b0; line_end = 1'b0;
    endtask

    task automatic wr_reg(input int num, input logic [7:0] v, input logic strobe);
        put_byte(v, 1'b0);
        put_byte(8'h80 | 8'(num), strobe);
    endtask

    task automatic strobe_line();
        @(negedge clk); line_end = 1'b1;
        @(negedge clk); line_end = 1'b0;
    endtask

    function automatic int exp_mode(input logic [7:0] r0, input logic [7:0] r1);
        return ((int'(r0) >> 1) & 7) * 4 + ((int'(r1) >> 3) & 3);
    endfunction

    initial begin
        logic [7:0] r0 = '0;
        logic [7:0] r1 = '0;
        logic [7:0] base = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mode", int'(mode_act), 0);
        chk("R1 blank", int'(disp_en), 0);
        chk("R1 base", int'(name_base), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 base immediate sweep
        for (int v = 0; v < 256; v++) begin
            wr_reg(2, 8'(v), 1'b0);
            chk("R4 base", int'(name_base), v);
            chk("R4 mode untouched", int'(mode_act), 0);
        end
        base = 8'hFF;

        // R5 / R6 register 1 sweep
        for (int v = 0; v < 256; v++) begin
            wr_reg(1, 8'(v), 1'b0);
            chk("R5 before strobe", int'(disp_en), int'(r1[6]));
            chk("R6 before strobe", int'(mode_act), exp_mode(r0, r1));
            strobe_line();
            r1 = 8'(v);
            chk("R5 after strobe", int'(disp_en), int'(r1[6]));
            chk("R6 after strobe", int'(mode_act), exp_mode(r0, r1));
        end

        // R6 register 0 sweep
        for (int v = 0; v < 256; v++) begin
            wr_reg(0, 8'(v), 1'b0);
            chk("R6 r0 before strobe", int'(mode_act), exp_mode(r0, r1));
            strobe_line();
            r0 = 8'(v);
            chk("R6 r0 after strobe", int'(mode_act), exp_mode(r0, r1));
        end

        // R2 data byte alone
        put_byte(8'h55, 1'b0);
        chk("R2 data byte alone", int'(name_base), int'(base));
        put_byte(8'h82, 1'b0);
        base = 8'h55;
        chk("R2 commit", int'(name_base), int'(base));

        // R3 abandon then resync
        put_byte(8'h11, 1'b0);
        put_byte(8'h02, 1'b0);
        chk("R3 abandon", int'(name_base), int'(base));
        put_byte(8'h82, 1'b0);
        chk("R3 new data byte", int'(name_base), int'(base));
        put_byte(8'h82, 1'b0);
        base = 8'h82;
        chk("R3 resync commit", int'(name_base), int'(base));

        // R7 last write wins
        wr_reg(1, 8'h40, 1'b0);
        wr_reg(1, 8'h00, 1'b0);
        wr_reg(1, 8'h58, 1'b0);
        strobe_line();
        r1 = 8'h58;
        chk("R7 blank", int'(disp_en), 1);
        chk("R7 mode", int'(mode_act), exp_mode(r0, r1));

        // R8 write during blanking skips one strobe
        @(negedge clk); hblank = 1'b1;
        wr_reg(1, 8'h00, 1'b0);
        @(negedge clk); hblank = 1'b0;
        strobe_line();
        chk("R8 skipped strobe", int'(disp_en), 1);
        strobe_line();
        r1 = 8'h00;
        chk("R8 second strobe", int'(disp_en), 0);
        chk("R8 mode", int'(mode_act), exp_mode(r0, r1));

        // R9 write coincident with strobe
        wr_reg(1, 8'h40, 1'b1);
        chk("R9 not same strobe", int'(disp_en), 0);
        strobe_line();
        r1 = 8'h40;
        chk("R9 next strobe", int'(disp_en), 1);

        // R11 newer write replaces parked value
        @(negedge clk); hblank = 1'b1;
        wr_reg(1, 8'h00, 1'b0);
        @(negedge clk); hblank = 1'b0;
        wr_reg(1, 8'h48, 1'b0);
        strobe_line();
        r1 = 8'h48;
        chk("R11 blank", int'(disp_en), 1);
        chk("R11 mode", int'(mode_act), exp_mode(r0, r1));
        strobe_line();
        chk("R11 parked value gone", int'(disp_en), 1);

        // R10 other registers ignored
        for (int n = 3; n < 128; n++) begin
            wr_reg(n, 8'hFF - 8'(n), 1'b0);
            strobe_line();
            chk("R10 mode", int'(mode_act), exp_mode(r0, r1));
            chk("R10 blank", int'(disp_en), int'(r1[6]));
            chk("R10 base", int'(name_base), int'(base));
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule